// File: doc/BRIEF.md
# Grouped Channel Output Disable Gate

This block sits between the per-channel output drivers of a timer engine and the device pins. Channels are arranged in contiguous groups of eight, and each group has one external disable input. While a group's disable input is asserted, every channel in that group that has opted in is forced to its own safe level. That safe level is the inverse of the channel's active-polarity bit. Channels that have not opted in pass their normal output through unchanged.

Each disable input is brought into the clock domain by a two-flop synchroniser. The gated outputs are registered, so the pins stay glitch-free when a disable input or a configuration bit changes. Each channel has a two-bit configuration word, written over a simple bus made of a write strobe, a channel index and data. A status vector shows which channels are being forced at the moment.

The default build has 32 channels and four disable inputs. The 64-channel, eight-input build for a dual-engine part uses the same grouping and is selected by parameter.

Top module: `out_disable_gate`

## Requirements
- R1: While `rstN` is low, `chanOut` and `forced` are all zero, and every channel's polarity and opt-in bits clear to 0. After reset, with no configuration written, asserting every disable input leaves `chanOut` equal to `chanIn` and `forced` at zero.
- R2: A channel whose opt-in bit is 0 drives `chanOut` with its `chanIn` value one clock edge later, even while its group's disable input is asserted.
- R3: A channel whose opt-in bit is 1 and whose group disable is active drives `chanOut` with the inverse of its polarity bit.
- R4: Disable input g (0-based) controls exactly channels 8g to 8g+7 and no other channel.
- R5: A change on a disable input shows on `chanOut` and `forced` after the third rising clock edge following the change, and not after the second. Assertion and release both follow this rule.
- R6: A write with `wrEn`=1 loads `wrData` bit 0 as the channel's polarity bit and bit 1 as its opt-in bit, for the channel given by `wrIdx`. The new setting shows on the outputs after the second rising edge counted from the write edge.
- R7: Several disable inputs asserted at the same time each act on their own group only, and the groups do not affect each other.
- R8: `forced[i]` is 1 exactly when channel i is opted in and its group's synchronised disable is active. It is registered in step with `chanOut`.
- R9: With `DIS_ACT_HIGH`=1 a disable input is active when high. With `DIS_ACT_HIGH`=0 it is active when low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| disIn | input | NUM_CH/GRP_SIZE | Raw disable input, one per group |
| wrEn | input | 1 | Configuration write strobe |
| wrIdx | input | clog2(NUM_CH) | Channel index of the write |
| wrData | input | 2 | Bit 0 is the polarity bit, bit 1 is the opt-in bit |
| chanIn | input | NUM_CH | Channel outputs from the timer engine |
| chanOut | output | NUM_CH | Registered, gated outputs to the pins |
| forced | output | NUM_CH | Per-channel flag showing the channel is being forced |

## Verification
A vector table runs a fixed mixed configuration through these disable patterns: none asserted, each input on its own, two non-adjacent pairs, and all four at once. The single-input patterns show whether each input reaches the right block of eight channels. The pairs and the all-asserted pattern show that groups do not leak into each other. Because the polarity and opt-in patterns vary within each group, the same vectors also separate a forced channel from a passed-through one and a forced high level from a forced low level. Directed tests then check the edge-by-edge latency of the synchroniser and of a configuration write, and check that a non-opted channel follows a toggling input while its group is disabled.

// File: rtl/odg_pkg.sv
package odg_pkg;
  // Strobe bundle sent from control to datapath for one configuration write.
  typedef struct packed {
    logic wrStb;   // a valid write this cycle
    logic polBit;  // new polarity bit
    logic enBit;   // new opt-in bit
  } cfgStrobe_t;
endpackage

// File: rtl/odg_ctrl.sv
module odg_ctrl
  import odg_pkg::*;
#(
  parameter int NUM_CH       = 32,
  parameter int NUM_GRP      = 4,
  parameter int IDX_W        = 5,
  parameter bit DIS_ACT_HIGH = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_GRP-1:0] disIn,
  input  logic               wrEn,
  input  logic [IDX_W-1:0]   wrIdx,
  input  logic [1:0]         wrData,
  output cfgStrobe_t         cfgStb,
  output logic [IDX_W-1:0]   cfgIdx,
  output logic [NUM_GRP-1:0] grpActive
);
  logic [NUM_GRP-1:0] disNorm;
  logic [NUM_GRP-1:0] syncA;
  logic [NUM_GRP-1:0] syncB;
  logic [1:0]         age;

  // Convert to active-high before synchronising, so reset means "inactive".
  assign disNorm = DIS_ACT_HIGH ? disIn : ~disIn;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncA[g] <= 1'b0;
        syncB[g] <= 1'b0;
      end else begin
        syncA[g] <= disNorm[g];
        syncB[g] <= syncA[g];
      end
    end
  end

  assign grpActive = syncB;

  always_comb begin
    cfgStb.wrStb  = wrEn && (int'(wrIdx) < NUM_CH);
    cfgStb.polBit = wrData[0];
    cfgStb.enBit  = wrData[1];
    cfgIdx        = wrIdx;
  end

  // Counts edges since reset, stops at 3; used only to qualify checks.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              age <= 2'd0;
    else if (age != 2'd3)   age <= age + 2'd1;
  end

  // R5: the synchronised level is the normalised input from two edges back.
  p_sync_lat_r5: assert property (@(posedge clk) disable iff (!rstN)
    (age == 2'd3) |-> (grpActive == $past(disNorm, 2)));

  // R9: a freshly synchronised bit was produced by the normalised input.
  p_sync_pol_r9: assert property (@(posedge clk) disable iff (!rstN)
    (age != 2'd0) |-> (syncA == $past(disNorm)));
endmodule

// File: rtl/odg_dpath.sv
module odg_dpath
  import odg_pkg::*;
#(
  parameter int NUM_CH   = 32,
  parameter int GRP_SIZE = 8,
  parameter int NUM_GRP  = 4,
  parameter int IDX_W    = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  cfgStrobe_t         cfgStb,
  input  logic [IDX_W-1:0]   cfgIdx,
  input  logic [NUM_GRP-1:0] grpActive,
  input  logic [NUM_CH-1:0]  chanIn,
  output logic [NUM_CH-1:0]  chanOut,
  output logic [NUM_CH-1:0]  forced
);
  logic [NUM_CH-1:0] polReg;
  logic [NUM_CH-1:0] enReg;
  logic [NUM_CH-1:0] forceNow;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam int GRP = i / GRP_SIZE;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        polReg[i] <= 1'b0;
        enReg[i]  <= 1'b0;
      end else if (cfgStb.wrStb && (cfgIdx == IDX_W'(i))) begin
        polReg[i] <= cfgStb.polBit;
        enReg[i]  <= cfgStb.enBit;
      end
    end

    assign forceNow[i] = enReg[i] & grpActive[GRP];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chanOut[i] <= 1'b0;
        forced[i]  <= 1'b0;
      end else begin
        chanOut[i] <= forceNow[i] ? ~polReg[i] : chanIn[i];
        forced[i]  <= forceNow[i];
      end
    end

    // R3: a forced channel sits at the inverse of the polarity it had.
    p_safe_level_r3: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && forced[i]) |-> (chanOut[i] != $past(polReg[i])));

    // R2: a channel not being forced follows its input one edge later.
    p_pass_thru_r2: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && !forced[i]) |-> (chanOut[i] == $past(chanIn[i])));

    // R8: forcing needs the opt-in bit and the group's active disable.
    p_forced_src_r8: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && forced[i]) |-> ($past(enReg[i]) && $past(grpActive[GRP])));

    // R6: a write to this channel loads both bits.
    p_cfg_load_r6: assert property (@(posedge clk) disable iff (!rstN)
      (cfgStb.wrStb && (cfgIdx == IDX_W'(i))) |=>
        ((polReg[i] == $past(cfgStb.polBit)) && (enReg[i] == $past(cfgStb.enBit))));
  end
endmodule

// File: rtl/out_disable_gate.sv
module out_disable_gate
  import odg_pkg::*;
#(
  parameter int NUM_CH       = 32,
  parameter int GRP_SIZE     = 8,
  parameter bit DIS_ACT_HIGH = 1'b1,
  localparam int NUM_GRP     = NUM_CH / GRP_SIZE,
  localparam int IDX_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_GRP-1:0] disIn,
  input  logic               wrEn,
  input  logic [IDX_W-1:0]   wrIdx,
  input  logic [1:0]         wrData,
  input  logic [NUM_CH-1:0]  chanIn,
  output logic [NUM_CH-1:0]  chanOut,
  output logic [NUM_CH-1:0]  forced
);
  cfgStrobe_t         cfgStb;
  logic [IDX_W-1:0]   cfgIdx;
  logic [NUM_GRP-1:0] grpActive;

  odg_ctrl #(
    .NUM_CH(NUM_CH), .NUM_GRP(NUM_GRP), .IDX_W(IDX_W), .DIS_ACT_HIGH(DIS_ACT_HIGH)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .disIn(disIn), .wrEn(wrEn), .wrIdx(wrIdx),
    .wrData(wrData), .cfgStb(cfgStb), .cfgIdx(cfgIdx), .grpActive(grpActive)
  );

  odg_dpath #(
    .NUM_CH(NUM_CH), .GRP_SIZE(GRP_SIZE), .NUM_GRP(NUM_GRP), .IDX_W(IDX_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .cfgStb(cfgStb), .cfgIdx(cfgIdx),
    .grpActive(grpActive), .chanIn(chanIn), .chanOut(chanOut), .forced(forced)
  );
endmodule

// File: tb/sim_out_disable_gate.sv
module sim_out_disable_gate;
  logic        clk = 1'b0;
  logic        rstN;
  logic [3:0]  disIn;
  logic        wrEn;
  logic [4:0]  wrIdx;
  logic [1:0]  wrData;
  logic [31:0] chanIn;
  logic [31:0] chanOut;
  logic [31:0] forced;

  int total = 0;
  int bad   = 0;
  logic [31:0] enCfg  = 32'hA5C3_0FF1;
  logic [31:0] polCfg = 32'h3C96_55AA;

  always #10 clk = ~clk;

  out_disable_gate u0 (
    .clk(clk), .rstN(rstN), .disIn(disIn), .wrEn(wrEn), .wrIdx(wrIdx),
    .wrData(wrData), .chanIn(chanIn), .chanOut(chanOut), .forced(forced)
  );

  // Vector layout: {disable[3:0], chanIn[31:0]}
  localparam logic [35:0] VEC [8] = '{
    {4'b0000, 32'hDEAD_BEEF}, {4'b0001, 32'h0000_0000},
    {4'b0010, 32'hFFFF_FFFF}, {4'b0100, 32'h1234_5678},
    {4'b1000, 32'h8765_4321}, {4'b0101, 32'hF0F0_0F0F},
    {4'b1010, 32'h0F0F_F0F0}, {4'b1111, 32'h5555_AAAA}
  };

  // Expected values taken from R3, R4 and R8.
  function automatic logic [31:0] expForce(input logic [3:0] d);
    logic [31:0] r;
    for (int c = 0; c < 32; c++) r[c] = enCfg[c] & d[c / 8];
    return r;
  endfunction

  function automatic logic [31:0] expOut(input logic [3:0] d, input logic [31:0] x);
    logic [31:0] f;
    f = expForce(d);
    return (f & ~polCfg) | (~f & x);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cfgWrite(input int ch, input logic [1:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrIdx = 5'(ch); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0; disIn = 4'h0; wrEn = 1'b0; wrIdx = '0; wrData = '0;
    chanIn = 32'hFFFF_FFFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 chanOut in reset", chanOut, 32'h0);
    chk("R1 forced in reset", forced, 32'h0);
    rstN = 1'b1;
    disIn = 4'hF;
    chanIn = 32'h9ABC_DEF0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 cleared opt-in chanOut", chanOut, 32'h9ABC_DEF0);
    chk("R1 cleared opt-in forced", forced, 32'h0);
    disIn = 4'h0;
    repeat (3) @(posedge clk);

    for (int c = 0; c < 32; c++) cfgWrite(c, {enCfg[c], polCfg[c]});

    // Vector table: R3 R4 R7 R8
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      disIn  = VEC[v][35:32];
      chanIn = VEC[v][31:0];
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk($sformatf("R3 R4 R7 vec%0d chanOut", v), chanOut, expOut(disIn, chanIn));
      chk($sformatf("R8 R4 vec%0d forced", v), forced, expForce(disIn));
    end

    // R5 latency on assertion and on release, with input 1
    @(negedge clk);
    disIn = 4'h0; chanIn = 32'h0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    disIn = 4'b0010;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R5 not yet forced after 2 edges", forced, 32'h0);
    @(negedge clk);
    chk("R5 forced after 3 edges", forced, expForce(4'b0010));
    disIn = 4'b0000;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R5 still forced 2 edges after release", forced, expForce(4'b0010));
    @(negedge clk);
    chk("R5 released after 3 edges", forced, 32'h0);

    // R6 write latency: channel 1 starts not opted in, group 0 active
    disIn = 4'b0001; chanIn = 32'hFFFF_FFFF;
    repeat (4) @(posedge clk);
    @(negedge clk);
    wrEn = 1'b1; wrIdx = 5'd1; wrData = 2'b11;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
    chk("R6 chanOut unchanged one edge after write", {31'h0, chanOut[1]}, 32'h1);
    chk("R6 forced unchanged one edge after write", {31'h0, forced[1]}, 32'h0);
    @(negedge clk);
    chk("R6 chanOut at inverse polarity two edges after write", {31'h0, chanOut[1]}, 32'h0);
    chk("R6 forced two edges after write", {31'h0, forced[1]}, 32'h1);
    enCfg[1] = 1'b1; polCfg[1] = 1'b1;

    // R2: channel 2 not opted in follows a toggling input under active group 0
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chanIn[2] = k[0];
      @(negedge clk);
      chk("R2 pass-through under disable", {31'h0, chanOut[2]}, {31'h0, k[0]});
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule